// File: doc/BRIEF.md
# 800x600 Raster Timing Generator

This block produces the line and frame timing for an 800x600, 60 Hz display. It runs from a 40 MHz pixel clock, which another block derives from the 100 MHz board clock. It outputs active-high horizontal and vertical sync pulses and a video-on flag. It also outputs the raw horizontal and vertical counts, which downstream drawing logic compares against object bounds. A line is 1056 pixel clocks long and a frame is 628 lines long.

Each count begins with its sync pulse, followed by the back porch, then the visible area, then the front porch. Because of this ordering, visible pixels occupy counts 216 to 1015 horizontally and lines 27 to 626 vertically. Drawing logic must therefore subtract those offsets to get screen coordinates.

Each axis is a small phase machine with four named states, each paired with a counter:
- `PH_SYNC` moves to `PH_BACK` on the last sync count.
- `PH_BACK` moves to `PH_ACTIVE` on the last back-porch count.
- `PH_ACTIVE` moves to `PH_FRONT` on the last visible count.
- `PH_FRONT` moves back to `PH_SYNC` when the count wraps to 0.

The horizontal machine advances on every clock. The vertical machine advances only on the clock in which the horizontal count wraps.

Top module: `vga_sync_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, both counts become 0, `video_on` is 0, and `hsync` and `vsync` are 1, because count 0 lies in the sync phase.
- R2: After reset, `hcount` increases by 1 on every clock from 0 up to 1055, and then returns to 0.
- R3: `vcount` changes only on the clock edge where `hcount` goes from 1055 to 0. It increases by 1 up to 627, and a wrap at line 627 returns it to 0.
- R4: `hsync` is 1 exactly when `hcount` is in 0..127 (128 clocks), in the same cycle as that count value.
- R5: `vsync` is 1 exactly when `vcount` is in 0..3.
- R6: The horizontal visible window is `hcount` 216..1015, giving 800 pixels. This leaves an 88-clock back porch and a 40-clock front porch.
- R7: The vertical visible window is `vcount` 27..626, giving 600 lines. This leaves a 1-line front porch.
- R8: `video_on` is 1 exactly when `hcount` is inside the R6 window and `vcount` is inside the R7 window at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync pulse, active high |
| vsync | output | 1 | Vertical sync pulse, active high |
| video_on | output | 1 | High while the current pixel is visible |
| hcount | output | 11 | Horizontal count, 0..1055 |
| vcount | output | 10 | Vertical count, 0..627 |

## Verification
The assertions assume that `rst` is high from time zero until after the first clock edge. Every property is disabled while `rst` is high, so the only input they depend on is a clean clock. The bench holds `rst` high over several edges at start-up and again in the middle of a run, and releases it on a falling edge.

A full default frame is longer than the cycle budget. The bench therefore also instantiates a second copy with a reduced geometry, which exercises the vertical front porch and frame wrap many times over.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    // Phase of one axis; order of the enumeration follows the count order.
    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

endpackage

// File: rtl/vga_axis_timer.sv
module vga_axis_timer
    import vga_timing_pkg::*;
#(
    parameter int SYNC_LEN   = 128,
    parameter int BACK_LEN   = 88,
    parameter int ACTIVE_LEN = 800,
    parameter int FRONT_LEN  = 40,
    localparam int TOTAL     = SYNC_LEN + BACK_LEN + ACTIVE_LEN + FRONT_LEN,
    localparam int CW        = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [CW-1:0] count,
    output phase_e        phase,
    output logic          wrap
);

    localparam logic [CW-1:0] SYNC_LAST   = CW'(SYNC_LEN - 1);
    localparam logic [CW-1:0] BACK_FIRST  = CW'(SYNC_LEN);
    localparam logic [CW-1:0] BACK_LAST   = CW'(SYNC_LEN + BACK_LEN - 1);
    localparam logic [CW-1:0] ACT_FIRST   = CW'(SYNC_LEN + BACK_LEN);
    localparam logic [CW-1:0] ACT_LAST    = CW'(SYNC_LEN + BACK_LEN + ACTIVE_LEN - 1);
    localparam logic [CW-1:0] FRONT_FIRST = CW'(SYNC_LEN + BACK_LEN + ACTIVE_LEN);
    localparam logic [CW-1:0] COUNT_LAST  = CW'(TOTAL - 1);

    logic [CW-1:0] count_q, count_d;
    phase_e        phase_q, phase_d;
    logic          at_last;

    assign at_last = (count_q == COUNT_LAST);
    assign wrap    = advance && at_last;

    always_comb begin
        count_d = count_q;
        if (advance) begin
            count_d = at_last ? '0 : count_q + 1'b1;
        end
    end

    // Next-phase logic: leave a phase on its final count.
    always_comb begin
        phase_d = phase_q;
        if (advance) begin
            unique case (phase_q)
                PH_SYNC:   if (count_q == SYNC_LAST)  phase_d = PH_BACK;
                PH_BACK:   if (count_q == BACK_LAST)  phase_d = PH_ACTIVE;
                PH_ACTIVE: if (count_q == ACT_LAST)   phase_d = PH_FRONT;
                PH_FRONT:  if (count_q == COUNT_LAST) phase_d = PH_SYNC;
                default:                              phase_d = PH_SYNC;
            endcase
        end
    end

    // State register together with its counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            phase_q <= PH_SYNC;
        end else begin
            count_q <= count_d;
            phase_q <= phase_d;
        end
    end

    assign count = count_q;
    assign phase = phase_q;

    // R2 / R3: the count never leaves its range.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count_q <= COUNT_LAST);

    // R2 / R3: a wrap lands on zero.
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && at_last) |=> (count_q == '0) && (phase_q == PH_SYNC));

    // R3: without advance nothing moves.
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count_q) && $stable(phase_q));

    // R4 / R5: the phase register agrees with the sync window of the count.
    assert_sync_window_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC) == (count_q <= SYNC_LAST));

    assert_back_window_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BACK) == ((count_q >= BACK_FIRST) && (count_q <= BACK_LAST)));

    // R6 / R7: the active phase covers exactly the visible counts.
    assert_active_window_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACTIVE) == ((count_q >= ACT_FIRST) && (count_q < FRONT_FIRST)));

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
    import vga_timing_pkg::*;
#(
    parameter int H_SYNC   = 128,
    parameter int H_BACK   = 88,
    parameter int H_ACTIVE = 800,
    parameter int H_FRONT  = 40,
    parameter int V_SYNC   = 4,
    parameter int V_BACK   = 23,
    parameter int V_ACTIVE = 600,
    parameter int V_FRONT  = 1,
    localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          hsync,
    output logic          vsync,
    output logic          video_on,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

    phase_e h_phase, v_phase;
    logic   h_wrap, v_wrap;

    vga_axis_timer #(
        .SYNC_LEN   (H_SYNC),
        .BACK_LEN   (H_BACK),
        .ACTIVE_LEN (H_ACTIVE),
        .FRONT_LEN  (H_FRONT)
    ) u_h_axis (
        .clk     (clk),
        .rst     (rst),
        .advance (1'b1),
        .count   (hcount),
        .phase   (h_phase),
        .wrap    (h_wrap)
    );

    vga_axis_timer #(
        .SYNC_LEN   (V_SYNC),
        .BACK_LEN   (V_BACK),
        .ACTIVE_LEN (V_ACTIVE),
        .FRONT_LEN  (V_FRONT)
    ) u_v_axis (
        .clk     (clk),
        .rst     (rst),
        .advance (h_wrap),
        .count   (vcount),
        .phase   (v_phase),
        .wrap    (v_wrap)
    );

    // Output decode straight from the two phase registers.
    always_comb begin
        hsync    = (h_phase == PH_SYNC);
        vsync    = (v_phase == PH_SYNC);
        video_on = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
    end

    // R2: the horizontal count steps by one until it wraps.
    assert_hstep_R2: assert property (@(posedge clk) disable iff (rst)
        (hcount != H_LAST) |=> (hcount == $past(hcount) + 1'b1));

    // R3: the line count only moves on a horizontal wrap.
    assert_vstep_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(vcount) |-> ($past(hcount) == H_LAST));

    // R3: frame wrap happens only at the last pixel of the last line.
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        v_wrap |-> (hcount == H_LAST));

    // R8: visible pixels never overlap a sync pulse.
    assert_video_no_sync_R8: assert property (@(posedge clk) disable iff (rst)
        video_on |-> (!hsync && !vsync));

endmodule

// File: tb/vga_sync_gen_bench.sv
module vga_sync_gen_bench;

    localparam int D_HS = 128, D_HB = 88, D_HA = 800, D_HF = 40;
    localparam int D_VS = 4,   D_VB = 23, D_VA = 600, D_VF = 1;
    localparam int S_HS = 8,   S_HB = 4,  S_HA = 16,  S_HF = 4;
    localparam int S_VS = 2,   S_VB = 3,  S_VA = 5,   S_VF = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        hsync, vsync, video_on;
    logic [10:0] hcount;
    logic [9:0]  vcount;
    logic        s_hsync, s_vsync, s_video_on;
    logic [4:0]  s_hcount;
    logic [3:0]  s_vcount;

    vga_sync_gen u_vga_sync_gen (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .video_on(video_on), .hcount(hcount), .vcount(vcount)
    );

    vga_sync_gen #(
        .H_SYNC(S_HS), .H_BACK(S_HB), .H_ACTIVE(S_HA), .H_FRONT(S_HF),
        .V_SYNC(S_VS), .V_BACK(S_VB), .V_ACTIVE(S_VA), .V_FRONT(S_VF)
    ) u_small (
        .clk(clk), .rst(rst), .hsync(s_hsync), .vsync(s_vsync),
        .video_on(s_video_on), .hcount(s_hcount), .vcount(s_vcount)
    );

    int checks = 0;
    int errors = 0;
    int n = 0;       // clocks since the last reset edge
    bit done = 1'b0;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic check_one(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at n=%0d: actual=%0d expected=%0d", req, what, n, act, exp);
        end
    endtask

    task automatic compare_geom(input string tag,
                                input int hs, input int hb, input int ha, input int hf,
                                input int vs, input int vb, input int va, input int vf,
                                input int a_h, input int a_v,
                                input int a_hs, input int a_vs, input int a_vo);
        int ht, vt, eh, ev, hact, vact;
        ht   = hs + hb + ha + hf;
        vt   = vs + vb + va + vf;
        eh   = n % ht;
        ev   = (n / ht) % vt;
        hact = int'(eh >= hs + hb && eh < hs + hb + ha);
        vact = int'(ev >= vs + vb && ev < vs + vb + va);
        check_one("R2", {tag, " hcount"}, a_h, eh);
        check_one("R3", {tag, " vcount"}, a_v, ev);
        check_one("R4", {tag, " hsync"}, a_hs, int'(eh < hs));
        check_one("R5", {tag, " vsync"}, a_vs, int'(ev < vs));
        check_one("R8 (R6/R7 windows)", {tag, " video_on"}, a_vo, hact & vact);
    endtask

    task automatic compare_all();
        compare_geom("full", D_HS, D_HB, D_HA, D_HF, D_VS, D_VB, D_VA, D_VF,
                     int'(hcount), int'(vcount), int'(hsync), int'(vsync), int'(video_on));
        compare_geom("small", S_HS, S_HB, S_HA, S_HF, S_VS, S_VB, S_VA, S_VF,
                     int'(s_hcount), int'(s_vcount), int'(s_hsync), int'(s_vsync), int'(s_video_on));
    endtask

    task automatic run_checked(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic check_reset_state();
        check_one("R1", "hcount", int'(hcount), 0);
        check_one("R1", "vcount", int'(vcount), 0);
        check_one("R1", "video_on", int'(video_on), 0);
        check_one("R1", "hsync", int'(hsync), 1);
        check_one("R1", "vsync", int'(vsync), 1);
        check_one("R1", "small hcount", int'(s_hcount), 0);
        check_one("R1", "small vcount", int'(s_vcount), 0);
    endtask

    // R1: reset from power-up.
    task automatic test_startup_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
    endtask

    // R2, R4, R6: the whole first line, every pixel.
    task automatic test_first_line();
        run_checked(D_HS + D_HB + D_HA + D_HF + 2);
    endtask

    // R3, R5: through the vertical sync lines into the back porch.
    task automatic test_vsync_lines();
        while (n < 6 * 1056) run_checked(1);
    endtask

    // R7, R8: into the first visible lines of the frame.
    task automatic test_visible_entry();
        while (n < 30 * 1056) run_checked(1);
    endtask

    // R1: reset in the middle of a visible line, then restart.
    task automatic test_midrun_reset();
        while (int'(hcount) != 500) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        run_checked(1200);
    endtask

    // R3, R5, R7: several full frames of the reduced geometry.
    task automatic test_small_frames();
        run_checked(3 * 32 * 11 + 5);
    endtask

    initial begin
        test_startup_reset();
        test_first_line();
        test_vsync_lines();
        test_visible_entry();
        test_midrun_reset();
        test_small_frames();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule